// File: doc/BRIEF.md
# Direct Wake-up Line Masking Controller

This block serves wake-up lines whose source peripheral keeps its own interrupt flag. The block therefore stores no pending state for these lines. Each line input is brought into the bus clock domain and its rising edge is found. Two per-line mask bits then decide what the edge may do: an interrupt-enable bit and an event-enable bit. An enabled edge raises a CPU wake-up request, and the event-enable bit also produces a one-cycle CPU event pulse for the downstream event generator.

The wake-up requests of all lines are merged into a single CPU wake-up output, which is registered in the bus clock domain. That output is ORed with an external wake-up input to form the system wake-up output. A line's wake-up request stays asserted while its input remains high after the enabling edge. Software reads and writes the two mask vectors through a small register port that has one select bit.

Top module: `dwk_wakeup_ctrl`

## Requirements
- R1: After reset the interrupt-enable vector reads all ones, the event-enable vector reads all zeros, and `cpu_wakeup`, `sys_wakeup` (with `other_wkup` low) and `cpu_event` are 0.
- R2: A write with `reg_we`=1 loads `reg_wdata` into the interrupt-enable vector when `reg_sel`=0, or into the event-enable vector when `reg_sel`=1, at the next clock edge. `reg_rdata` returns the vector selected by `reg_sel`.
- R3: With bit i of the interrupt-enable vector set and bit i of the event-enable vector clear, a rising edge on `line_in[i]` sets `cpu_wakeup` and `sys_wakeup` three clock edges after the input changes, and `cpu_event` stays 0.
- R4: Only a rising edge triggers a line. An input that was already high when its masks were enabled, or an input that falls, causes no wake-up and no event.
- R5: If both mask bits of a line are 0, a rising edge on that line produces neither a wake-up nor an event.
- R6: If only the event-enable bit of a line is set, a rising edge produces both a CPU event pulse and a CPU wake-up.
- R7: If both mask bits of a line are set, a rising edge produces both a CPU event pulse and a CPU wake-up in the same cycle.
- R8: A line's wake-up request stays asserted while its input stays high and clears three clock edges after the input falls. `cpu_wakeup` stays high as long as any requesting line is still high.
- R9: `sys_wakeup` is the OR of `cpu_wakeup` and `other_wkup`, with no added clock delay.
- R10: Each enabled rising edge gives a `cpu_event` pulse exactly one clock cycle long, even when the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | N_LINES | Asynchronous direct wake-up lines |
| reg_we | input | 1 | Mask register write strobe |
| reg_sel | input | 1 | 0 selects the interrupt-enable vector, 1 selects the event-enable vector |
| reg_wdata | input | N_LINES | Mask write data |
| reg_rdata | output | N_LINES | Selected mask vector |
| other_wkup | input | 1 | Wake-up request from other sources |
| cpu_wakeup | output | 1 | Merged CPU wake-up request, registered in the bus clock domain |
| sys_wakeup | output | 1 | System wake-up request |
| cpu_event | output | 1 | One-cycle CPU event request pulse |

## Verification
The hardest case to reach is a line that is already high when its masks become enabled. The design must show that a level alone never triggers a line. The stimulus raises the line while both masks are clear, waits for the synchroniser to settle, enables the interrupt bit, and then watches for several cycles that no wake-up appears. It then drops the line and raises it again, which shows that the same line does wake the system on a real rising edge. Overlapping high periods on two lines confirm that the merged wake-up is held until the last line falls.

// File: rtl/dwk_pkg.sv
package dwk_pkg;

    localparam int unsigned DWK_LINES = 8;
    localparam int unsigned DWK_SYNC_STAGES = 2;

    typedef enum logic {
        SEL_IRQ_EN = 1'b0,
        SEL_EVT_EN = 1'b1
    } mask_sel_e;

    typedef struct packed {
        logic level;
        logic rise;
    } line_stat_t;

    function automatic logic wake_allowed(input logic irq_en, input logic evt_en);
        return irq_en | evt_en;
    endfunction

    function automatic logic event_allowed(input logic evt_en);
        return evt_en;
    endfunction

endpackage

// File: rtl/dwk_edge.sv
module dwk_edge
    import dwk_pkg::*;
#(
    parameter int unsigned N_LINES = DWK_LINES
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_LINES-1:0]         line_in,
    output line_stat_t [N_LINES-1:0]   stat
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic [DWK_SYNC_STAGES-1:0] sync_q;
        logic                       dly_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                dly_q  <= 1'b0;
            end else begin
                sync_q <= {sync_q[DWK_SYNC_STAGES-2:0], line_in[i]};
                dly_q  <= sync_q[DWK_SYNC_STAGES-1];
            end
        end

        always_comb begin
            stat[i].level = sync_q[DWK_SYNC_STAGES-1];
            stat[i].rise  = sync_q[DWK_SYNC_STAGES-1] & ~dly_q;
        end

        // R10: an edge indication never lasts two cycles
        p_rise_single_r10: assert property (@(posedge clk) disable iff (rst)
            stat[i].rise |=> !stat[i].rise);
    end

endmodule

// File: rtl/dwk_mask_regs.sv
module dwk_mask_regs
    import dwk_pkg::*;
#(
    parameter int unsigned N_LINES = DWK_LINES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  mask_sel_e          sel,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] rdata,
    output logic [N_LINES-1:0] irq_en,
    output logic [N_LINES-1:0] evt_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en <= '1;
            evt_en <= '0;
        end else if (we) begin
            if (sel == SEL_IRQ_EN) irq_en <= wdata;
            else                   evt_en <= wdata;
        end
    end

    always_comb rdata = (sel == SEL_IRQ_EN) ? irq_en : evt_en;

    p_reset_masks_r1: assert property (@(posedge clk)
        $past(rst) |-> (irq_en == '1 && evt_en == '0));

    p_irq_write_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && $past(sel) == SEL_IRQ_EN) |-> irq_en == $past(wdata));

    p_evt_write_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && $past(sel) == SEL_EVT_EN) |-> evt_en == $past(wdata));

endmodule

// File: rtl/dwk_combine.sv
module dwk_combine
    import dwk_pkg::*;
#(
    parameter int unsigned N_LINES = DWK_LINES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  line_stat_t [N_LINES-1:0] stat,
    input  logic [N_LINES-1:0]       irq_en,
    input  logic [N_LINES-1:0]       evt_en,
    output logic [N_LINES-1:0]       hold_q,
    output logic [N_LINES-1:0]       evt_q
);

    logic [N_LINES-1:0] level_v;
    logic [N_LINES-1:0] hold_d;
    logic [N_LINES-1:0] evt_d;

    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            level_v[i] = stat[i].level;
            evt_d[i]   = stat[i].rise & event_allowed(evt_en[i]);
            if (stat[i].rise && wake_allowed(irq_en[i], evt_en[i]))
                hold_d[i] = 1'b1;
            else
                hold_d[i] = hold_q[i] & stat[i].level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            evt_q  <= '0;
        end else begin
            hold_q <= hold_d;
            evt_q  <= evt_d;
        end
    end

    // R5: a new wake-up needs at least one mask bit set
    p_masked_no_wake_r5: assert property (@(posedge clk) disable iff (rst)
        (hold_q & ~$past(hold_q) & ~($past(irq_en) | $past(evt_en))) == '0);

    // R6: an event pulse needs the event-enable bit
    p_evt_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
        (evt_q & ~$past(evt_en)) == '0);

    // R8: a request cannot survive a low synchronised input
    p_drop_on_low_r8: assert property (@(posedge clk) disable iff (rst)
        (hold_q & ~$past(level_v)) == '0);

    // R10: per line, event pulses are never back to back
    p_evt_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_q != '0) |=> (evt_q & $past(evt_q)) == '0);

endmodule

// File: rtl/dwk_wakeup_ctrl.sv
module dwk_wakeup_ctrl
    import dwk_pkg::*;
#(
    parameter int unsigned N_LINES = DWK_LINES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] line_in,
    input  logic               reg_we,
    input  logic               reg_sel,
    input  logic [N_LINES-1:0] reg_wdata,
    output logic [N_LINES-1:0] reg_rdata,
    input  logic               other_wkup,
    output logic               cpu_wakeup,
    output logic               sys_wakeup,
    output logic               cpu_event
);

    line_stat_t [N_LINES-1:0] stat;
    logic [N_LINES-1:0]       irq_en;
    logic [N_LINES-1:0]       evt_en;
    logic [N_LINES-1:0]       hold_q;
    logic [N_LINES-1:0]       evt_q;

    dwk_edge #(.N_LINES(N_LINES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .stat    (stat)
    );

    dwk_mask_regs #(.N_LINES(N_LINES)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .sel    (mask_sel_e'(reg_sel)),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .irq_en (irq_en),
        .evt_en (evt_en)
    );

    dwk_combine #(.N_LINES(N_LINES)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .stat   (stat),
        .irq_en (irq_en),
        .evt_en (evt_en),
        .hold_q (hold_q),
        .evt_q  (evt_q)
    );

    always_comb begin
        cpu_wakeup = |hold_q;
        cpu_event  = |evt_q;
        sys_wakeup = cpu_wakeup | other_wkup;
    end

    p_sys_covers_cpu_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_wakeup |-> sys_wakeup);

    p_event_wakes_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_event |-> cpu_wakeup);

endmodule

// File: tb/dwk_wakeup_ctrl_bench.sv
module dwk_wakeup_ctrl_bench;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] line_in = '0;
    logic         reg_we = 1'b0;
    logic         reg_sel = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         other_wkup = 1'b0;
    logic         cpu_wakeup, sys_wakeup, cpu_event;

    always #2.5 clk = ~clk;

    dwk_wakeup_ctrl #(.N_LINES(N)) u_dwk_wakeup_ctrl (
        .clk(clk), .rst(rst), .line_in(line_in),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .other_wkup(other_wkup), .cpu_wakeup(cpu_wakeup),
        .sys_wakeup(sys_wakeup), .cpu_event(cpu_event)
    );

    typedef struct {
        int    at;
        logic  wk;
        logic  ev;
        logic  sy;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (cpu_wakeup !== e.wk || cpu_event !== e.ev || sys_wakeup !== e.sy) begin
                n_bad++;
                $display("FAIL %s cyc=%0d: wk/ev/sys actual=%b%b%b expected=%b%b%b",
                         e.tag, cyc, cpu_wakeup, cpu_event, sys_wakeup, e.wk, e.ev, e.sy);
            end
        end
    end

    task automatic expect_at(input int dc, input logic wk, input logic ev,
                             input logic sy, input string tag);
        exp_t e;
        e.at = cyc + dc; e.wk = wk; e.ev = ev; e.sy = sy; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [N-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic sel, input logic [N-1:0] exp, input string tag);
        reg_sel = sel;
        #0.5;
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata actual=%h expected=%h", tag, reg_rdata, exp);
        end
    endtask

    task automatic set_line(input int i, input logic v);
        @(negedge clk);
        line_in[i] = v;
    endtask

    initial begin
        cycles(3);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_check(1'b0, '1, "R1 irq_en reset");
        rd_check(1'b1, '0, "R1 evt_en reset");
        expect_at(1, 0, 0, 0, "R1 outputs after reset");
        cycles(2);

        // R2 register port
        wr(1'b0, 8'hA5); rd_check(1'b0, 8'hA5, "R2 irq write");
        wr(1'b1, 8'h3C); rd_check(1'b1, 8'h3C, "R2 evt write");
        rd_check(1'b0, 8'hA5, "R2 irq unaffected");
        wr(1'b0, 8'hFF); wr(1'b1, 8'h00);

        // R3 interrupt-enabled line 0
        set_line(0, 1'b1);
        expect_at(2, 0, 0, 0, "R3 not before third edge");
        expect_at(3, 1, 0, 1, "R3 wake, no event");
        expect_at(4, 1, 0, 1, "R3 no event");
        expect_at(8, 1, 0, 1, "R8 held while high");
        cycles(9);
        set_line(0, 1'b0);
        expect_at(2, 1, 0, 1, "R8 still held");
        expect_at(3, 0, 0, 0, "R8 dropped after fall");
        cycles(5);

        // R5 both masks clear
        wr(1'b0, 8'h00);
        set_line(1, 1'b1);
        expect_at(3, 0, 0, 0, "R5 masked line");
        expect_at(5, 0, 0, 0, "R5 masked line later");
        cycles(6);
        set_line(1, 1'b0);
        cycles(4);

        // R6 event-only line 2, R10 pulse width
        wr(1'b1, 8'h04);
        set_line(2, 1'b1);
        expect_at(3, 1, 1, 1, "R6 event and wake");
        expect_at(4, 1, 0, 1, "R10 pulse one cycle");
        expect_at(6, 1, 0, 1, "R10 no repeat while high");
        cycles(7);
        set_line(2, 1'b0);
        expect_at(3, 0, 0, 0, "R6 wake released");
        cycles(5);

        // R7 both masks line 3
        wr(1'b0, 8'h08); wr(1'b1, 8'h08);
        set_line(3, 1'b1);
        expect_at(3, 1, 1, 1, "R7 both outputs");
        expect_at(4, 1, 0, 1, "R10 single pulse");
        cycles(5);
        set_line(3, 1'b0);
        cycles(5);

        // R4 level and falling edge do not trigger
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
        set_line(4, 1'b1);
        cycles(6);
        wr(1'b0, 8'h10);
        for (int k = 1; k <= 5; k++) expect_at(k, 0, 0, 0, "R4 level ignored");
        cycles(6);
        set_line(4, 1'b0);
        expect_at(3, 0, 0, 0, "R4 falling ignored");
        expect_at(5, 0, 0, 0, "R4 falling ignored later");
        cycles(6);
        set_line(4, 1'b1);
        expect_at(3, 1, 0, 1, "R4 real rising edge wakes");
        cycles(4);
        set_line(4, 1'b0);
        expect_at(3, 0, 0, 0, "R4 release");
        cycles(5);

        // R8 overlapping lines 5 and 6
        wr(1'b0, 8'h60);
        set_line(5, 1'b1);
        cycles(1);
        set_line(6, 1'b1);
        cycles(4);
        set_line(5, 1'b0);
        expect_at(3, 1, 0, 1, "R8 other line keeps wake");
        expect_at(5, 1, 0, 1, "R8 other line keeps wake later");
        cycles(6);
        set_line(6, 1'b0);
        expect_at(3, 0, 0, 0, "R8 last line released");
        cycles(5);

        // R9 external wake source
        @(negedge clk);
        other_wkup = 1'b1;
        expect_at(0, 0, 0, 1, "R9 external only");
        cycles(2);
        set_line(7, 1'b1);
        wr(1'b0, 8'h80);
        expect_at(1, 1, 0, 1, "R9 both sources");
        cycles(2);
        @(negedge clk);
        other_wkup = 1'b0;
        expect_at(0, 1, 0, 1, "R9 cpu wake alone");
        cycles(2);
        set_line(7, 1'b0);
        expect_at(3, 0, 0, 0, "R9 all released");
        cycles(6);
        done = 1;
    end

    initial begin
        int waited;
        waited = 0;
        while (!done && waited < 50000) begin
            @(posedge clk);
            waited++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: done actual=0 expected=1");
        end
        if (q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: leftover actual=%0d expected=0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule